// File: doc/BRIEF.md
# Wide simple dual-port RAM with byte lanes

This block is a two-port memory with one port that only writes and one port that only reads. Each port has its own clock and clock enable. Words are built from 9-bit lanes. A full-size instance has eight lanes, which makes a 72-bit word. A half-size instance has four lanes, which makes a 36-bit word. Both sizes hold 512 words. The write port takes one write enable per lane, so any subset of the lanes of a word can be updated in a single cycle.

The read port has one output register. That register has three controls:
- a value it takes at power-up;
- a synchronous clear to a chosen value, which acts only while the read clock enable is high;
- a hold, which applies whenever the read clock enable is low.

A build-time setting, `WMODE`, decides what a read returns when it hits the word being written on the same edge. `RD_FIRST` returns the stored contents from before the write. `WR_FIRST` returns the new lanes merged over the old ones.

`RD_FIRST` is only meaningful when both ports run from one clock. `WR_FIRST` also works with unrelated clocks. Across unrelated clocks, however, a same-address collision has no defined result. The memory array also has a build-time fill value for every word.

Top module: `ramw_sdp`

## Requirements
- R1: With `WIDE`=1 the data ports are 72 bits wide with 8 lanes. With `WIDE`=0 they are 36 bits wide with 4 lanes. In both cases the word address is 9 bits, for 512 words. Lane b occupies data bits [9b+8:9b].
- R2: On a rising `clk_w` edge with `ce_w`=1, each lane b of word `waddr` whose `we[b]`=1 takes lane b of `wdata`. Lanes whose enable is 0 keep their contents.
- R3: On a rising `clk_r` edge with `ce_r`=1 and `rst_r`=0, `rdata` takes the word stored at `raddr`. It is visible after that edge.
- R4: With `WMODE`=`RD_FIRST` and a shared clock, a read of the word written on the same edge returns the contents from before that write.
- R5: With `WMODE`=`WR_FIRST` and a shared clock, a read of the word written on the same edge returns the old word with every enabled lane replaced by the new lane.
- R6: While `ce_r`=0, `rdata` keeps its value on every edge, whatever `rst_r` is.
- R7: On an edge with `ce_r`=1 and `rst_r`=1, `rdata` takes `RST_VAL`. This clear takes priority over the read.
- R8: Before the first enabled read edge, `rdata` equals `OUT_INIT`. Every word that has not been written reads as `MEM_FILL`.
- R9: An edge with `ce_w`=0 writes nothing, even when lane enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Write port clock |
| ce_w | input | 1 | Write port clock enable |
| we | input | LANES | Per-lane write enables |
| waddr | input | AW | Write word address |
| wdata | input | DW | Write data |
| clk_r | input | 1 | Read port clock |
| ce_r | input | 1 | Read port clock enable |
| rst_r | input | 1 | Synchronous output clear, qualified by ce_r |
| raddr | input | AW | Read word address |
| rdata | output | DW | Registered read data |

## Verification
A lane written wrongly, or written when it should not have been, stays hidden until that word is read. It then appears one read edge later, as a 9-bit field that differs from the bench's model. A wrong forwarding decision at a collision shows on `rdata` right after that edge. It shows as old data where new data was expected, or the other way round, lane by lane. A faulty output register shows at once and persists through every cycle in which the read clock enable is low. The bench therefore focuses its random addresses on sixteen words to make collisions and re-reads frequent.

// File: rtl/ramw_pkg.sv
package ramw_pkg;
  localparam int LANE_W = 9;
  localparam int MAX_W  = 72;

  typedef enum logic {
    RD_FIRST = 1'b0,
    WR_FIRST = 1'b1
  } wmode_e;

  function automatic int lanes_of(input bit wide);
    return wide ? 8 : 4;
  endfunction

  // bit-granular address span minus the low bits consumed by the widest word
  function automatic int addr_bits(input bit wide);
    return wide ? (15 - 6) : (14 - 5);
  endfunction
endpackage

// File: rtl/ramw_array.sv
module ramw_array #(
  parameter int LANES = 8,
  parameter int AW    = 9,
  parameter logic [ramw_pkg::MAX_W-1:0] MEM_FILL = '0
) (
  input  logic                               clk_w,
  input  logic                               ce_w,
  input  logic [LANES-1:0]                   we,
  input  logic [AW-1:0]                      waddr,
  input  logic [LANES*ramw_pkg::LANE_W-1:0]  wdata,
  input  logic [AW-1:0]                      raddr,
  output logic [LANES*ramw_pkg::LANE_W-1:0]  rd_raw
);
  localparam int LW    = ramw_pkg::LANE_W;
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = MEM_FILL[DW-1:0];
  end

  always_ff @(posedge clk_w) begin
    if (ce_w) begin
      for (int b = 0; b < LANES; b++) begin
        if (we[b]) mem[waddr][b*LW +: LW] <= wdata[b*LW +: LW];
      end
    end
  end

  assign rd_raw = mem[raddr];

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // an enabled lane holds the written data after the edge
    assert_lane_write_R2: assert property (@(posedge clk_w)
      ce_w && we[g] |=> mem[$past(waddr)][g*LW +: LW] == $past(wdata[g*LW +: LW]));
  end

  // a disabled write port leaves the addressed word untouched
  assert_idle_write_R9: assert property (@(posedge clk_w)
    !ce_w |=> mem[$past(waddr)] == $past(mem[waddr]));
endmodule

// File: rtl/ramw_collide.sv
module ramw_collide #(
  parameter int LANES = 8,
  parameter int AW    = 9,
  parameter ramw_pkg::wmode_e WMODE = ramw_pkg::RD_FIRST
) (
  input  logic                               ce_w,
  input  logic [LANES-1:0]                   we,
  input  logic [AW-1:0]                      waddr,
  input  logic [LANES*ramw_pkg::LANE_W-1:0]  wdata,
  input  logic [AW-1:0]                      raddr,
  input  logic [LANES*ramw_pkg::LANE_W-1:0]  rd_raw,
  output logic [LANES*ramw_pkg::LANE_W-1:0]  rd_fwd
);
  localparam int LW  = ramw_pkg::LANE_W;
  localparam bit FWD = (WMODE == ramw_pkg::WR_FIRST);

  logic hit;
  assign hit = FWD && ce_w && (waddr == raddr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_fwd[g*LW +: LW] = (hit && we[g]) ? wdata[g*LW +: LW] : rd_raw[g*LW +: LW];
  end
endmodule

// File: rtl/ramw_outreg.sv
module ramw_outreg #(
  parameter int DW = 72,
  parameter logic [ramw_pkg::MAX_W-1:0] RST_VAL  = '0,
  parameter logic [ramw_pkg::MAX_W-1:0] OUT_INIT = '0
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          rst,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_r = OUT_INIT[DW-1:0];

  always_ff @(posedge clk) begin
    if (ce) q_r <= rst ? RST_VAL[DW-1:0] : d;
  end

  assign q = q_r;

  // clear is honoured only together with the enable
  assert_hold_R6: assert property (@(posedge clk) !ce |=> $stable(q));

  assert_clear_R7: assert property (@(posedge clk) ce && rst |=> q == RST_VAL[DW-1:0]);
endmodule

// File: rtl/ramw_sdp.sv
module ramw_sdp #(
  parameter bit WIDE = 1'b1,
  parameter ramw_pkg::wmode_e WMODE = ramw_pkg::RD_FIRST,
  parameter logic [ramw_pkg::MAX_W-1:0] RST_VAL  = '0,
  parameter logic [ramw_pkg::MAX_W-1:0] OUT_INIT = '0,
  parameter logic [ramw_pkg::MAX_W-1:0] MEM_FILL = '0,
  localparam int LANES = ramw_pkg::lanes_of(WIDE),
  localparam int DW    = LANES * ramw_pkg::LANE_W,
  localparam int AW    = ramw_pkg::addr_bits(WIDE)
) (
  input  logic             clk_w,
  input  logic             ce_w,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             clk_r,
  input  logic             ce_r,
  input  logic             rst_r,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] rd_raw;
  logic [DW-1:0] rd_fwd;

  ramw_array #(.LANES(LANES), .AW(AW), .MEM_FILL(MEM_FILL)) u_array (
    .clk_w(clk_w), .ce_w(ce_w), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rd_raw(rd_raw)
  );

  ramw_collide #(.LANES(LANES), .AW(AW), .WMODE(WMODE)) u_collide (
    .ce_w(ce_w), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rd_raw(rd_raw), .rd_fwd(rd_fwd)
  );

  ramw_outreg #(.DW(DW), .RST_VAL(RST_VAL), .OUT_INIT(OUT_INIT)) u_out (
    .clk(clk_r), .ce(ce_r), .rst(rst_r), .d(rd_fwd), .q(rdata)
  );

  // full-lane collision on a shared clock returns the new word (valid only with one clock)
  if (WMODE == ramw_pkg::WR_FIRST) begin : g_fwd_chk
    assert_new_data_R5: assert property (@(posedge clk_r) disable iff (rst_r)
      ce_r && ce_w && (&we) && (waddr == raddr) |=> rdata == $past(wdata));
  end
endmodule

// File: tb/sim_ramw_sdp.sv
`timescale 1ns/1ps
module sim_ramw_sdp;
  localparam logic [71:0] RST0  = 72'h1F0E1D2C3B4A596877;
  localparam logic [71:0] INIT0 = 72'h0123456789ABCDEF01;
  localparam logic [71:0] FILL0 = 72'h5A5A5A5A5A5A5A5A5A;
  localparam logic [71:0] RST1  = 72'h00000000_9C0FFEE12 & 72'hF_FFFF_FFFF;
  localparam logic [71:0] INIT1 = 72'h3456789AB;
  localparam logic [71:0] FILL1 = 72'h5A5A5A5A5;
  localparam logic [71:0] M36   = 72'hF_FFFF_FFFF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        ce_w = 1'b0, ce_r = 1'b0, rst_r = 1'b0;
  logic [7:0]  we = '0;
  logic [8:0]  waddr = '0, raddr = '0;
  logic [71:0] wdata = '0;
  logic [71:0] rd0;
  logic [35:0] rd1;

  ramw_sdp #(.WIDE(1'b1), .WMODE(ramw_pkg::RD_FIRST), .RST_VAL(RST0),
             .OUT_INIT(INIT0), .MEM_FILL(FILL0)) u0 (
    .clk_w(clk), .ce_w(ce_w), .we(we), .waddr(waddr), .wdata(wdata),
    .clk_r(clk), .ce_r(ce_r), .rst_r(rst_r), .raddr(raddr), .rdata(rd0));

  ramw_sdp #(.WIDE(1'b0), .WMODE(ramw_pkg::WR_FIRST), .RST_VAL(RST1),
             .OUT_INIT(INIT1), .MEM_FILL(FILL1)) u1 (
    .clk_w(clk), .ce_w(ce_w), .we(we[3:0]), .waddr(waddr), .wdata(wdata[35:0]),
    .clk_r(clk), .ce_r(ce_r), .rst_r(rst_r), .raddr(raddr), .rdata(rd1));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [71:0] m0 [512];
  logic [71:0] m1 [512];
  logic [71:0] e0 = INIT0;
  logic [71:0] e1 = INIT1;

  function automatic logic [71:0] mrg(input logic [71:0] old, input logic [71:0] d,
                                      input logic [7:0] w, input int n);
    logic [71:0] r = old;
    for (int b = 0; b < n; b++) if (w[b]) r[b*9 +: 9] = d[b*9 +: 9];
    return r;
  endfunction

  task automatic check(input logic [71:0] act, input logic [71:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic cw, input logic [7:0] wv, input logic [8:0] wa,
                      input logic [71:0] wd, input logic cr, input logic rs,
                      input logic [8:0] ra, input string tag);
    string t0, t1;
    logic hit;
    ce_w = cw; we = wv; waddr = wa; wdata = wd; ce_r = cr; rst_r = rs; raddr = ra;
    hit = cw && (wa == ra);
    if (cr) begin
      e0 = rs ? RST0 : m0[ra];
      e1 = rs ? RST1 : (hit ? mrg(m1[ra], wd & M36, wv, 4) : m1[ra]);
    end
    if (cw) begin
      m0[wa] = mrg(m0[wa], wd, wv, 8);
      m1[wa] = mrg(m1[wa], wd & M36, wv, 4);
    end
    if (tag != "") begin t0 = tag; t1 = tag; end
    else if (!cr) begin t0 = "R6"; t1 = "R6"; end
    else if (rs) begin t0 = "R7"; t1 = "R7"; end
    else if (hit) begin t0 = "R4"; t1 = "R5"; end
    else begin t0 = "R3"; t1 = "R3"; end
    @(posedge clk);
    @(negedge clk);
    check(rd0, e0, {t0, " full/read-first"});
    check({36'b0, rd1}, e1, {t1, " half/write-first"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [95:0] r96;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) begin m0[i] = FILL0; m1[i] = FILL1; end
    #1;
    // power-up register value
    check(rd0, INIT0, "R8 output init full");
    check({36'b0, rd1}, INIT1, "R8 output init half");
    check(72'($bits(rd0)), 72'd72, "R1 full width");
    check(72'($bits(rd1)), 72'd36, "R1 half width");
    @(negedge clk);
    step(1'b0, 8'hFF, 9'd5, 72'h0, 1'b1, 1'b0, 9'd5, "R8 fill");
    step(1'b1, 8'hFF, 9'd5, 72'h111222333444555666, 1'b0, 1'b1, 9'd5, "R6");
    step(1'b0, 8'hFF, 9'd5, 72'h0ABCDEF0123456789A, 1'b1, 1'b0, 9'd5, "R2");
    step(1'b0, 8'hFF, 9'd5, 72'h0, 1'b1, 1'b0, 9'd5, "R9");
    step(1'b1, 8'b0000_0101, 9'd5, 72'hFEDCBA987654321FED, 1'b0, 1'b0, 9'd5, "R6");
    step(1'b0, 8'h00, 9'd5, 72'h0, 1'b1, 1'b0, 9'd5, "R2 partial");
    step(1'b1, 8'hFF, 9'd6, 72'h777888999AAABBBCCC, 1'b1, 1'b0, 9'd6, "");
    step(1'b1, 8'b1010_0110, 9'd6, 72'h135792468ACE024681, 1'b1, 1'b0, 9'd6, "");
    step(1'b0, 8'h00, 9'd6, 72'h0, 1'b1, 1'b1, 9'd6, "R7 priority");
    step(1'b0, 8'h00, 9'd6, 72'h0, 1'b1, 1'b0, 9'd6, "R3");
    step(1'b0, 8'h00, 9'd300, 72'h0, 1'b1, 1'b0, 9'd511, "R8 top word");
    for (int k = 0; k < 600; k++) begin
      r96 = {$urandom(), $urandom(), $urandom()};
      step(1'($urandom() % 2), 8'($urandom()), 9'($urandom() % 16), r96[71:0],
           ($urandom() % 4) != 0, ($urandom() % 8) == 0, 9'($urandom() % 16), "");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule